// File: doc/BRIEF.md
# SPI Serial Flash Target Front End

This block is the target-side front end of a serial flash memory on a four-wire SPI bus (mode 0) with an additional hold pin. It runs on a fast core clock, samples the bus pins through a two-stage synchronizer and finds the serial clock edges itself. Received bits are taken on rising edges of the serial clock. The output shifter moves only after falling edges.

Every transfer is MSB first. The first byte is an opcode. A read opcode is followed by a 24-bit address, and the block then streams bytes from a small synchronous RAM for as long as chip select stays low. That RAM stands in for the full 4 MiB array (64 sectors of 256 pages of 256 bytes). A core-side load port fills it in one clock per byte. The status, identification and signature opcodes return fixed bytes.

The output is split into a data line and an enable. The enable is low whenever the target is deselected, paused by hold, not yet armed, or has nothing to send.

Top module: `spi_flash_target`

The controller has eight states:

| State | Meaning |
|---|---|
| ST_IDLE | Deselected. |
| ST_OPCODE | Collecting the opcode. |
| ST_ADDR | Collecting three address bytes. |
| ST_READ | Streaming array bytes. |
| ST_STATUS | Repeating the status byte. |
| ST_ID | Alternating the two identification bytes. |
| ST_SIG | Repeating the signature byte. |
| ST_IGNORE | Unknown opcode received. |

The transitions are:
- Any state goes to ST_IDLE on deselect, or while the target is not armed.
- ST_IDLE goes to ST_OPCODE once the target is selected and not held.
- ST_OPCODE goes to ST_READ via ST_ADDR (0x03), to ST_STATUS (0x05), to ST_ID (0x9F), to ST_SIG (0xAB), or to ST_IGNORE (any other byte), on the eighth rising edge.
- ST_ADDR goes to ST_READ on the last rising edge of the third address byte.
- The four output states and ST_IGNORE stay where they are until deselect.

## Requirements
- R1: Input bits are taken MSB first on rising edges of the serial clock. The output data line changes only after a falling edge, so its value is unchanged across a rising edge.
- R2: While chip select is high the output enable is low. Raising chip select abandons a partly received command, and the next selection starts with a fresh opcode.
- R3: After reset no command is accepted, and the output enable stays low, until a falling edge has been seen on chip select.
- R4: While hold is low and the target is selected, the output enable is low and serial clock and data are ignored. When hold is released the transfer continues from the same bit.
- R5: Driving hold low while deselected has no effect on the next command.
- R6: Opcode 0xAB returns the byte 0x15, repeated for as long as clocks continue.
- R7: Opcode 0x9F returns 0x20, then 0x16, alternating for as long as clocks continue.
- R8: Opcode 0x05 returns the status byte {3'b000, BP2, BP1, BP0, 2'b00}, repeated. With the default protect bits 3'b101 the byte is 0x14.
- R9: Opcode 0x03 takes a 24-bit address, sent MSB first. The array has 2^AW bytes and its index is the low AW address bits. The block returns consecutive bytes starting at that index and wraps from the top index to zero.
- R10: After an unknown opcode the output enable stays low until chip select rises. The next command then works normally.
- R11: A load-port write with load_we high stores load_data at load_addr on that clock. A later read returns the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, which oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_hold_n | input | 1 | Hold, active low |
| spi_mosi | input | 1 | Serial data in |
| load_we | input | 1 | Array load strobe |
| load_addr | input | AW | Array load index |
| load_data | input | 8 | Array load byte |
| spi_miso | output | 1 | Serial data out, 0 when the enable is low |
| spi_miso_oe | output | 1 | Output enable for the data line (tri-state control) |

## Verification
Two events can be seen in the same core cycle: a serial clock falling edge, which loads the next output byte, and the rising of chip select, which deselects the target. The bench provokes this in the middle of a read by lowering the serial clock and raising chip select in the same time step. Deselect must win. The output enable must drop, and the next command must return a correct status byte instead of continuing the read.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

    localparam int ADDR_W = 24;

    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_IDENT  = 8'h9F;
    localparam logic [7:0] OP_SIG    = 8'hAB;

    localparam logic [7:0] SIG_BYTE  = 8'h15;
    localparam logic [7:0] ID_BYTE0  = 8'h20;
    localparam logic [7:0] ID_BYTE1  = 8'h16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_READ,
        ST_STATUS,
        ST_ID,
        ST_SIG,
        ST_IGNORE
    } tgt_state_t;

    function automatic tgt_state_t decode_op(input logic [7:0] op);
        unique case (op)
            OP_READ:   return ST_ADDR;
            OP_STATUS: return ST_STATUS;
            OP_IDENT:  return ST_ID;
            OP_SIG:    return ST_SIG;
            default:   return ST_IGNORE;
        endcase
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int          N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] d_sync,
    output logic [N-1:0] d_prev
);

    logic [N-1:0] stage1;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[i] <= RST_VAL[i];
                d_sync[i] <= RST_VAL[i];
                d_prev[i] <= RST_VAL[i];
            end else begin
                stage1[i] <= d_in[i];
                d_sync[i] <= stage1[i];
                d_prev[i] <= d_sync[i];
            end
        end
    end

endmodule

// File: rtl/spi_flash_ram.sv
module spi_flash_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/spi_tx_source.sv
module spi_tx_source
    import spi_flash_pkg::*;
(
    input  tgt_state_t  state,
    input  logic [7:0]  status,
    input  logic        id_sel,
    input  logic [7:0]  ram_rdata,
    output logic [7:0]  next_byte
);

    always_comb begin
        unique case (state)
            ST_READ:   next_byte = ram_rdata;
            ST_STATUS: next_byte = status;
            ST_ID:     next_byte = id_sel ? ID_BYTE1 : ID_BYTE0;
            ST_SIG:    next_byte = SIG_BYTE;
            default:   next_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/spi_flash_target.sv
module spi_flash_target
    import spi_flash_pkg::*;
#(
    parameter int         AW      = 8,
    parameter logic [2:0] BP_INIT = 3'b101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_cs_n,
    input  logic          spi_hold_n,
    input  logic          spi_mosi,
    input  logic          load_we,
    input  logic [AW-1:0] load_addr,
    input  logic [7:0]    load_data,
    output logic          spi_miso,
    output logic          spi_miso_oe
);

    localparam int          NSYNC   = 4;
    localparam logic [7:0]  STATUS  = {3'b000, BP_INIT, 2'b00};
    localparam logic [NSYNC-1:0] SYNC_RST = 4'b0100;

    logic [NSYNC-1:0] pin_s, pin_p;
    logic cs_n_s, cs_n_p, hold_n_s, sck_s, sck_p, mosi_s;
    logic unused_prev;

    spi_in_sync #(.N(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   ({spi_cs_n, spi_hold_n, spi_sck, spi_mosi}),
        .d_sync (pin_s),
        .d_prev (pin_p)
    );

    assign cs_n_s      = pin_s[3];
    assign cs_n_p      = pin_p[3];
    assign hold_n_s    = pin_s[2];
    assign sck_s       = pin_s[1];
    assign sck_p       = pin_p[1];
    assign mosi_s      = pin_s[0];
    assign unused_prev = pin_p[2] ^ pin_p[0];

    tgt_state_t state, nxt;
    logic        armed;
    logic [2:0]  bit_cnt;
    logic [1:0]  addr_cnt;
    logic [7:0]  shreg, tx_reg, byte_in, next_byte, ram_rdata;
    logic [15:0] addr_acc;
    logic [ADDR_W-1:0] full_addr;
    logic [AW-1:0] rd_ptr;
    logic        id_sel;
    logic        unused_addr;

    logic cs_fall, sck_rise, sck_fall, selected, hold_act, rise_ok, fall_ok;
    logic out_state, byte_done;

    assign cs_fall   = ~cs_n_s & cs_n_p;
    assign sck_rise  = sck_s & ~sck_p;
    assign sck_fall  = ~sck_s & sck_p;
    assign selected  = armed & ~cs_n_s;
    assign hold_act  = selected & ~hold_n_s;
    assign rise_ok   = selected & ~hold_act & sck_rise;
    assign fall_ok   = selected & ~hold_act & sck_fall;
    assign byte_in   = {shreg[6:0], mosi_s};
    assign byte_done = rise_ok && (bit_cnt == 3'd7);
    assign full_addr = {addr_acc, byte_in};
    assign unused_addr = ^full_addr[ADDR_W-1:AW];
    assign out_state = (state == ST_READ) || (state == ST_STATUS) ||
                       (state == ST_ID)   || (state == ST_SIG);

    spi_flash_ram #(.AW(AW), .DW(8)) u_ram (
        .clk   (clk),
        .we    (load_we),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (rd_ptr),
        .rdata (ram_rdata)
    );

    spi_tx_source u_src (
        .state     (state),
        .status    (STATUS),
        .id_sel    (id_sel),
        .ram_rdata (ram_rdata),
        .next_byte (next_byte)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (!selected) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   nxt = hold_act ? ST_IDLE : ST_OPCODE;
                ST_OPCODE: if (byte_done) nxt = decode_op(byte_in);
                ST_ADDR:   if (byte_done && addr_cnt == 2'd2) nxt = ST_READ;
                ST_READ, ST_STATUS, ST_ID, ST_SIG, ST_IGNORE: nxt = state;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // Shift path and arming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            bit_cnt  <= '0;
            addr_cnt <= '0;
            shreg    <= '0;
            tx_reg   <= '0;
            addr_acc <= '0;
            rd_ptr   <= '0;
            id_sel   <= 1'b0;
        end else begin
            if (cs_fall) begin
                armed <= 1'b1;
            end
            if (!selected) begin
                bit_cnt  <= '0;
                addr_cnt <= '0;
                tx_reg   <= '0;
                id_sel   <= 1'b0;
            end else begin
                if (rise_ok) begin
                    shreg   <= byte_in;
                    bit_cnt <= bit_cnt + 3'd1;
                    if (state == ST_ADDR && bit_cnt == 3'd7) begin
                        addr_cnt <= addr_cnt + 2'd1;
                        addr_acc <= full_addr[15:0];
                        if (addr_cnt == 2'd2) begin
                            rd_ptr <= full_addr[AW-1:0];
                        end
                    end
                end
                if (fall_ok && out_state) begin
                    if (bit_cnt == 3'd0) begin
                        tx_reg <= next_byte;
                        if (state == ST_READ) rd_ptr <= rd_ptr + 1'b1;
                        if (state == ST_ID)   id_sel <= ~id_sel;
                    end else begin
                        tx_reg <= {tx_reg[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // Outputs
    always_comb begin
        spi_miso_oe = selected & ~hold_act & out_state;
        spi_miso    = spi_miso_oe & tx_reg[7];
    end

endmodule

// File: rtl/spi_flash_checker.sv
module spi_flash_checker
    import spi_flash_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_hold_n,
    input logic       spi_miso,
    input logic       spi_miso_oe,
    input logic       sck_fall,
    input logic       armed,
    input logic       hold_act,
    input tgt_state_t state,
    input logic [2:0] bit_cnt
);

    // R1: data line moves only in the cycle after a falling edge was seen
    a_r1_change_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_miso_oe && $past(spi_miso_oe) && (spi_miso != $past(spi_miso)))
        |-> $past(sck_fall));

    // R2: chip select high at the pin for three cycles means no drive
    a_r2_deselect_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso_oe);

    // R3: silent until the first chip select falling edge
    a_r3_unarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !spi_miso_oe);

    // R4: held pins for three cycles mean no drive
    a_r4_hold_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!spi_hold_n && !spi_cs_n, 1) && $past(!spi_hold_n && !spi_cs_n, 2) &&
         $past(!spi_hold_n && !spi_cs_n, 3))
        |-> !spi_miso_oe);

    // R4: hold freezes the controller state and the bit position
    a_r4_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act |=> ($stable(state) && $stable(bit_cnt)));

endmodule

bind spi_flash_target spi_flash_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_hold_n  (spi_hold_n),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .sck_fall    (sck_fall),
    .armed       (armed),
    .hold_act    (hold_act),
    .state       (state),
    .bit_cnt     (bit_cnt)
);

// File: tb/tb_spi_flash_target.sv
`timescale 1ns/1ps
module tb_spi_flash_target;

    localparam int  AW    = 8;
    localparam int  DEPTH = 1 << AW;
    localparam time HALF  = 40ns;
    localparam logic [7:0] EXP_STATUS = 8'h14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b0, hold_n = 1'b1, mosi = 1'b0;
    logic load_we = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic miso, oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [DEPTH];

    always #2.5 clk = ~clk;

    spi_flash_target #(.AW(AW), .BP_INIT(3'b101)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_hold_n(hold_n), .spi_mosi(mosi), .load_we(load_we),
        .load_addr(load_addr), .load_data(load_data),
        .spi_miso(miso), .spi_miso_oe(oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic load_byte(input int a, input logic [7:0] d);
        @(negedge clk);
        load_we = 1'b1; load_addr = a[AW-1:0]; load_data = d;
        @(negedge clk);
        load_we = 1'b0;
        model[a] = d;
    endtask

    task automatic spi_bit(input logic b, output logic r, output logic o);
        mosi = b;
        #HALF;
        r = miso; o = oe;
        sck = 1'b1;
        #HALF;
        sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] t, output logic [7:0] r, output int n);
        n = 0;
        for (int i = 7; i >= 0; i--) begin
            logic rb, ob;
            spi_bit(t[i], rb, ob);
            r[i] = rb;
            if (ob) n++;
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        #HALF;
    endtask

    task automatic cs_high();
        #HALF;
        cs_n = 1'b1;
        #(3 * HALF);
    endtask

    task automatic send_cmd(input logic [7:0] op);
        logic [7:0] r; int n;
        spi_byte(op, r, n);
    endtask

    task automatic send_addr(input logic [23:0] a);
        send_cmd(a[23:16]); send_cmd(a[15:8]); send_cmd(a[7:0]);
    endtask

    task automatic t_reset();
        #1ns;
        chk("R2 reset oe", oe, 1'b0);
        chk("R2 reset miso", miso, 1'b0);
    endtask

    task automatic t_unarmed();
        logic [7:0] r; int n;
        send_cmd(8'h9F);
        spi_byte(8'h00, r, n);
        chk("R3 no drive before first select edge", n, 0);
        spi_byte(8'h00, r, n);
        chk("R3 no drive second byte", n, 0);
        cs_high();
    endtask

    task automatic t_sig();
        logic [7:0] r; int n;
        cs_low(); send_cmd(8'hAB);
        for (int k = 0; k < 2; k++) begin
            spi_byte(8'h00, r, n);
            chk("R6 signature byte", r, 8'h15);
            chk("R6 signature drive", n, 8);
        end
        cs_high();
    endtask

    task automatic t_id();
        logic [7:0] r; int n;
        cs_low(); send_cmd(8'h9F);
        spi_byte(8'h00, r, n); chk("R7 id byte 0", r, 8'h20);
        spi_byte(8'h00, r, n); chk("R7 id byte 1", r, 8'h16);
        spi_byte(8'h00, r, n); chk("R7 id repeat", r, 8'h20);
        cs_high();
    endtask

    task automatic t_status(input string tag);
        logic [7:0] r; int n;
        cs_low(); send_cmd(8'h05);
        for (int k = 0; k < 3; k++) begin
            spi_byte(8'h00, r, n);
            chk(tag, r, EXP_STATUS);
        end
        cs_high();
    endtask

    task automatic t_read(input logic [23:0] a, input int cnt, input string tag);
        logic [7:0] r; int n;
        cs_low(); send_cmd(8'h03); send_addr(a);
        for (int k = 0; k < cnt; k++) begin
            spi_byte(8'h00, r, n);
            chk(tag, r, model[(int'(a[AW-1:0]) + k) % DEPTH]);
            chk({tag, " drive"}, n, 8);
        end
        cs_high();
    endtask

    task automatic t_r1_timing();
        logic r0, r1, r2;
        logic [7:0] e;
        e = model[8'h30];
        cs_low(); send_cmd(8'h03); send_addr(24'h000030);
        mosi = 1'b0;
        #HALF; r0 = miso;
        sck = 1'b1;
        #(HALF - 5ns); r1 = miso;
        #5ns; sck = 1'b0;
        #HALF; r2 = miso;
        chk("R1 msb first", r0, e[7]);
        chk("R1 stable across rising edge", r1, r0);
        chk("R1 next bit after falling edge", r2, e[6]);
        sck = 1'b1; #HALF; sck = 1'b0;
        cs_high();
    endtask

    task automatic t_unknown();
        logic [7:0] r; int n;
        cs_low(); send_cmd(8'h5A);
        spi_byte(8'h00, r, n); chk("R10 unknown opcode silent", n, 0);
        spi_byte(8'hAB, r, n); chk("R10 still silent", n, 0);
        cs_high();
        t_status("R10 status after unknown");
    endtask

    task automatic t_abandon();
        logic rb, ob;
        cs_low();
        for (int i = 7; i >= 4; i--) spi_bit(8'h03 >> i, rb, ob);
        cs_high();
        t_sig();
        chk("R2 abandon leaves oe low", oe, 1'b0);
    endtask

    task automatic t_hold();
        logic [7:0] r, b2; int n; logic rb, ob;
        cs_low(); send_cmd(8'h03); send_addr(24'h000040);
        spi_byte(8'h00, r, n); chk("R4 byte before hold", r, model[8'h40]);
        for (int i = 7; i >= 5; i--) begin spi_bit(1'b0, rb, ob); b2[i] = rb; end
        hold_n = 1'b0;
        #HALF;
        chk("R4 hold tristate", oe, 1'b0);
        for (int k = 0; k < 4; k++) begin
            mosi = k[0]; #HALF; sck = 1'b1; #HALF; sck = 1'b0;
            chk("R4 hold keeps oe low", oe, 1'b0);
        end
        hold_n = 1'b1;
        for (int i = 4; i >= 0; i--) begin spi_bit(1'b0, rb, ob); b2[i] = rb; end
        chk("R4 byte resumes across hold", b2, model[8'h41]);
        spi_byte(8'h00, r, n); chk("R4 byte after hold", r, model[8'h42]);
        cs_high();
    endtask

    task automatic t_hold_desel();
        hold_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #HALF; sck = 1'b1; #HALF; sck = 1'b0;
        end
        chk("R5 deselected hold no drive", oe, 1'b0);
        hold_n = 1'b1;
        #(2 * HALF);
        t_status("R5 status after deselected hold");
    endtask

    task automatic t_coincide();
        logic rb, ob;
        cs_low(); send_cmd(8'h03); send_addr(24'h000020);
        for (int i = 0; i < 2; i++) spi_bit(1'b0, rb, ob);
        mosi = 1'b0; #HALF; sck = 1'b1; #HALF;
        sck = 1'b0; cs_n = 1'b1;
        #(2 * HALF);
        chk("R2 deselect wins over falling edge", oe, 1'b0);
        #(2 * HALF);
        t_status("R2 status after coincident deselect");
    endtask

    initial begin : main
        for (int i = 0; i < DEPTH; i++) model[i] = 8'((i * 37 + 11) & 8'hFF);
        repeat (10) @(posedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        t_reset();
        for (int i = 0; i < DEPTH; i++) load_byte(i, model[i]);
        t_unarmed();
        t_sig();
        t_id();
        t_status("R8 status byte");
        t_read(24'h000010, 4, "R9 read");
        t_read(24'h1234FE, 3, "R9 read wrap");
        t_r1_timing();
        t_unknown();
        t_abandon();
        t_hold();
        t_hold_desel();
        t_coincide();
        load_byte(5, 8'hC3);
        t_read(24'h000005, 1, "R11 loaded byte");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #500us;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule